// File: doc/BRIEF.md
# Bus-Master DMA Descriptor Engine

This block is the bus-master data mover that sits beside a disk interface. Software programs a small register window. It writes a descriptor-table pointer, issues the transfer command to the disk side, and then sets the start bit. The engine then walks a table of 8-byte descriptors in memory and moves 32-bit words through a simple request/acknowledge memory master port. Depending on the direction bit, each word goes from the device stream into memory or from memory out to the device stream.

The disk side announces its transfer length with a one-cycle pulse. The engine counts that length down word by word, and it counts each descriptor's space down alongside it. The final status depends on which of the two counts runs out first:
- If the table runs out first, the status is 0.
- If both end together, the status is INTR only.
- If the device finishes first, the status is ACTIVE plus INTR. Software then clears start, and only INTR remains.

The interrupt line mirrors the INTR bit.

Top module: `busdma_engine`

## Requirements
- R1: After reset, the command byte, status byte, table pointer, `irq` and `mem_req` are all zero.
- R2: The register window is decoded as follows, and every other offset reads zero:
  - Offset 0 is the command byte: bit 0 is start, bit 3 is direction (1 = device to memory).
  - Offset 2 is the status byte: bit 0 is ACTIVE, bit 1 is ERROR, bit 2 is INTR. ERROR always reads 0.
  - Offset 4 is the 32-bit table pointer, and its low two bits always read zero.
- R3: Writing start while it is clear sets ACTIVE and fetches descriptors beginning at the table pointer. Each descriptor holds a buffer address word followed by a size word. Size bit 31 marks the last entry. Size bits 15:2 give the word count, and a count of zero means 16384 words (64 KiB).
- R4: With direction 1, device words are written in order to consecutive buffer addresses. With direction 0, buffer words are presented in order on `dev_dout` with a one-cycle `dev_put` strobe. Exactly min(device length, table space) words move.
- R5: When a non-last descriptor is used up, the next one is fetched 8 bytes further on, and its buffer continues the same word stream.
- R6: When the table space equals the device length, the final status is 0x4.
- R7: When the table ends before the device, the final status is 0x0, and no further memory requests follow the end of a transfer.
- R8: When the table is longer than the device length, the final status is 0x5. Writing the command with start clear then leaves 0x4.
- R9: Writing 1 to status bit 2 clears INTR. Writing 0 there, or writing to bits 0 and 1, changes nothing.
- R10: Clearing start in the middle of a transfer clears ACTIVE at once, leaves INTR as it was, and stops all memory requests.
- R11: `irq` is high exactly while INTR is set.
- R12: A memory request that is not acknowledged keeps its address and direction until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| dev_go | input | 1 | Device announces a new transfer |
| dev_len | input | LEN_W | Device transfer length in bytes (multiple of 4) |
| dev_din | input | 32 | Device-to-memory data word |
| dev_take | output | 1 | `dev_din` consumed this cycle |
| dev_dout | output | 32 | Memory-to-device data word |
| dev_put | output | 1 | `dev_dout` valid this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request accepted |
| irq | output | 1 | Interrupt, follows INTR |

## Verification
The bench builds the engine with its default 20-bit length width. It sweeps the following cases:
- one- and two-entry tables with 1 to 4 words per entry;
- device lengths of 1 to 8 words;
- both directions;
- alternate runs with the memory acknowledge stalled every third cycle.

Together these reach every short, exact and long relation, including those where the device length falls on a descriptor boundary. Directed runs add a zero size field standing for 64 KiB, a stop in the middle of a stalled transfer, and the register window's alignment and write-one-to-clear rules.

// File: rtl/busdma_pkg.sv
package busdma_pkg;
  localparam int PRD_SIZE_BITS = 16;
  localparam int WCNT_W        = PRD_SIZE_BITS - 1;

  localparam logic [2:0] OFS_CMD  = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd2;
  localparam logic [2:0] OFS_PTR  = 3'd4;

  localparam int CMD_START   = 0;
  localparam int CMD_DIR     = 3;
  localparam int STAT_ACTIVE = 0;
  localparam int STAT_INTR   = 2;
  localparam int SIZE_LAST   = 31;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH_A, S_FETCH_S, S_MOVE, S_HOLD
  } eng_state_t;

  // words described by a size field; an all-zero field is the maximum span
  function automatic logic [WCNT_W-1:0] prd_word_count(input logic [PRD_SIZE_BITS-3:0] w);
    if (w == '0) return WCNT_W'(1 << (PRD_SIZE_BITS - 2));
    return WCNT_W'(w);
  endfunction
endpackage

// File: rtl/busdma_regs.sv
module busdma_regs
  import busdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  input  logic        act_clr,
  input  logic        intr_set,
  output logic [31:0] rdata,
  output logic        start_evt,
  output logic        stop_evt,
  output logic        start_dir,
  output logic [31:0] table_ptr,
  output logic        active,
  output logic        intr
);
  logic        cmd_start, cmd_dir;
  logic [29:0] ptr_q;
  logic        cmd_wr, stat_wr, ptr_wr;
  logic        unused_wbit;

  assign cmd_wr    = wr_en && addr == OFS_CMD;
  assign stat_wr   = wr_en && addr == OFS_STAT;
  assign ptr_wr    = wr_en && addr == OFS_PTR;
  assign start_evt = cmd_wr && wdata[CMD_START] && !cmd_start;
  assign stop_evt  = cmd_wr && !wdata[CMD_START] && cmd_start;
  assign start_dir = wdata[CMD_DIR];
  assign table_ptr = {ptr_q, 2'b00};
  assign unused_wbit = wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_start <= 1'b0;
      cmd_dir   <= 1'b0;
      ptr_q     <= '0;
      active    <= 1'b0;
      intr      <= 1'b0;
    end else begin
      if (cmd_wr) begin
        cmd_start <= wdata[CMD_START];
        cmd_dir   <= wdata[CMD_DIR];
      end
      if (ptr_wr) ptr_q <= wdata[31:2];
      if (start_evt) active <= 1'b1;
      else if (stop_evt || act_clr) active <= 1'b0;
      if (intr_set) intr <= 1'b1;
      else if (stat_wr && wdata[STAT_INTR]) intr <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      OFS_CMD:  rdata = {28'd0, cmd_dir, 2'b00, cmd_start};
      OFS_STAT: rdata = {29'd0, intr, 1'b0, active};
      OFS_PTR:  rdata = table_ptr;
      default:  rdata = '0;
    endcase
  end

  a_r3_active_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(start_evt));
  a_r10_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !active);
  a_r8_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
    active && !stop_evt && !act_clr |=> active);
  a_r9_intr_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr && wdata[STAT_INTR] && !intr_set |=> !intr);
  a_r9_intr_keep: assert property (@(posedge clk) disable iff (!rst_n)
    intr && !(stat_wr && wdata[STAT_INTR]) |=> intr);
endmodule

// File: rtl/busdma_core.sv
module busdma_core
  import busdma_pkg::*;
#(
  parameter int LEN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             start_dir,
  input  logic [31:0]      table_ptr,
  input  logic             dev_go,
  input  logic [LEN_W-1:0] dev_len,
  input  logic [31:0]      dev_din,
  output logic             dev_take,
  output logic [31:0]      dev_dout,
  output logic             dev_put,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ack,
  output logic             act_clr,
  output logic             intr_set
);
  localparam int DW_W = LEN_W - 2;

  eng_state_t        state;
  logic              dir_q, last_q, dev_pend;
  logic [31:0]       ptr_cur, buf_addr;
  logic [WCNT_W-1:0] wleft;
  logic [DW_W-1:0]   dev_rem;
  logic              beat, word_beat, dev_done_w, tbl_end_w;
  logic [1:0]        unused_len;

  assign unused_len = dev_len[1:0];
  assign mem_req   = state == S_FETCH_A || state == S_FETCH_S || (state == S_MOVE && dev_pend);
  assign mem_we    = state == S_MOVE && dir_q;
  assign mem_wdata = dev_din;
  always_comb begin
    case (state)
      S_FETCH_A: mem_addr = ptr_cur;
      S_FETCH_S: mem_addr = ptr_cur + 32'd4;
      default:   mem_addr = buf_addr;
    endcase
  end

  // named events
  assign beat       = mem_req && mem_ack && !stop_evt;
  assign word_beat  = beat && state == S_MOVE;
  assign dev_done_w = word_beat && dev_rem == DW_W'(1);
  assign tbl_end_w  = word_beat && wleft == WCNT_W'(1) && last_q;
  assign dev_take   = word_beat && dir_q;
  assign act_clr    = tbl_end_w;
  assign intr_set   = dev_done_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      dir_q    <= 1'b0;
      last_q   <= 1'b0;
      dev_pend <= 1'b0;
      ptr_cur  <= '0;
      buf_addr <= '0;
      wleft    <= '0;
      dev_rem  <= '0;
      dev_put  <= 1'b0;
      dev_dout <= '0;
    end else begin
      dev_put <= word_beat && !dir_q;
      if (word_beat && !dir_q) dev_dout <= mem_rdata;
      if (dev_go) begin
        dev_rem  <= dev_len[LEN_W-1:2];
        dev_pend <= dev_len[LEN_W-1:2] != '0;
      end else if (word_beat) begin
        dev_rem <= dev_rem - DW_W'(1);
        if (dev_rem == DW_W'(1)) dev_pend <= 1'b0;
      end
      if (stop_evt) state <= S_IDLE;
      else begin
        case (state)
          S_IDLE: if (start_evt) begin
            state   <= S_FETCH_A;
            ptr_cur <= table_ptr;
            dir_q   <= start_dir;
          end
          S_FETCH_A: if (beat) begin
            buf_addr <= {mem_rdata[31:2], 2'b00};
            state    <= S_FETCH_S;
          end
          S_FETCH_S: if (beat) begin
            wleft   <= prd_word_count(mem_rdata[PRD_SIZE_BITS-1:2]);
            last_q  <= mem_rdata[SIZE_LAST];
            ptr_cur <= ptr_cur + 32'd8;
            state   <= S_MOVE;
          end
          S_MOVE: if (word_beat) begin
            buf_addr <= buf_addr + 32'd4;
            wleft    <= wleft - WCNT_W'(1);
            if (tbl_end_w) state <= S_IDLE;
            else if (dev_done_w) state <= S_HOLD;
            else if (wleft == WCNT_W'(1)) state <= S_FETCH_A;
          end
          default: ;
        endcase
      end
    end
  end

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !stop_evt |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  a_r7_quiet_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_end_w |=> !mem_req);
  a_r4_one_way: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_take && dev_put));
  a_r10_no_req_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !mem_req);
endmodule

// File: rtl/busdma_engine.sv
module busdma_engine
  import busdma_pkg::*;
#(
  parameter int LEN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             dev_go,
  input  logic [LEN_W-1:0] dev_len,
  input  logic [31:0]      dev_din,
  output logic             dev_take,
  output logic [31:0]      dev_dout,
  output logic             dev_put,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ack,
  output logic             irq
);
  logic        start_evt, stop_evt, start_dir, active, intr, act_clr, intr_set;
  logic [31:0] table_ptr;

  busdma_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .act_clr(act_clr), .intr_set(intr_set), .rdata(reg_rdata),
    .start_evt(start_evt), .stop_evt(stop_evt), .start_dir(start_dir),
    .table_ptr(table_ptr), .active(active), .intr(intr)
  );

  busdma_core #(.LEN_W(LEN_W)) u_core (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .start_dir(start_dir), .table_ptr(table_ptr), .dev_go(dev_go), .dev_len(dev_len),
    .dev_din(dev_din), .dev_take(dev_take), .dev_dout(dev_dout), .dev_put(dev_put),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .act_clr(act_clr), .intr_set(intr_set)
  );

  assign irq = intr;

  a_r11_irq_from_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(intr_set));
  a_r6_exact_idle: assert property (@(posedge clk) disable iff (!rst_n)
    intr_set && act_clr |=> irq && !reg_rdata_active_q);

  logic reg_rdata_active_q;
  assign reg_rdata_active_q = active;
endmodule

// File: tb/busdma_engine_tb_top.sv
module busdma_engine_tb_top;
  localparam int LEN_W = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr = 1'b0;
  logic [2:0]       reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic             dev_go = 1'b0;
  logic [LEN_W-1:0] dev_len = '0;
  logic [31:0]      dev_din = '0;
  logic             dev_take, dev_put, mem_req, mem_we, irq;
  logic [31:0]      dev_dout, mem_addr, mem_wdata;
  logic [31:0]      mem_rdata = '0;
  logic             mem_ack = 1'b0;

  busdma_engine #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dev_go(dev_go), .dev_len(dev_len), .dev_din(dev_din),
    .dev_take(dev_take), .dev_dout(dev_dout), .dev_put(dev_put), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .irq(irq)
  );

  initial forever #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0, dev_idx = 0, rx_n = 0, grants = 0, cur_run = 0;
  bit stall_en = 1'b0;
  bit finished = 1'b0;
  logic [31:0] mem [0:1023];
  logic [31:0] rx [0:127];

  function automatic logic [31:0] wpat(int r, int i);
    return 32'h5A000000 + (r << 8) + i;
  endfunction
  function automatic logic [31:0] rpat(int r, int a);
    return 32'hC3000000 + (r << 10) + a;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (run %0d)", req, act, exp, cur_run);
    end
  endtask

  // memory and device model
  initial forever begin
    @(negedge clk);
    cyc++;
    if (dev_put && rx_n < 128) begin rx[rx_n] = dev_dout; rx_n++; end
    if (mem_req && !(stall_en && (cyc % 3 == 0))) begin
      mem_ack = 1'b1;
      grants++;
      if (mem_we) begin
        mem[mem_addr[11:2]] = mem_wdata;
        dev_idx++;
        dev_din = wpat(cur_run, dev_idx);
      end else mem_rdata = mem[mem_addr[11:2]];
    end else mem_ack = 1'b0;
  end

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask
  task automatic dev_start(input int bytes);
    @(negedge clk); dev_go = 1'b1; dev_len = LEN_W'(bytes);
    @(negedge clk); dev_go = 1'b0;
  endtask

  task automatic prep(input bit dir, input int nd, input int s0, input int s1);
    reg_write(OFS(0), 32'd0);
    reg_write(OFS(2), 32'd4);
    cur_run++;
    stall_en = cur_run[0];
    mem[64] = 32'h400;
    mem[65] = (s0 * 4) | ((nd == 1) ? 32'h8000_0000 : 32'h0);
    mem[66] = 32'h500;
    mem[67] = (s1 * 4) | 32'h8000_0000;
    for (int j = 0; j < 128; j++) mem[256 + j] = dir ? 32'hDEADBEEF : rpat(cur_run, 256 + j);
    dev_idx = 0;
    dev_din = wpat(cur_run, 0);
    rx_n = 0;
    reg_write(OFS(4), 32'h100);
  endtask

  function automatic logic [2:0] OFS(int o);
    return 3'(o);
  endfunction

  task automatic run_case(input bit dir, input int nd, input int s0, input int s1, input int dw);
    int e0, total, moved, g0, cnt;
    logic [31:0] st, exp_st;
    bit ok;
    string tag;
    e0 = (s0 == 0) ? 16384 : s0;
    total = e0 + ((nd == 2) ? s1 : 0);
    moved = (dw < total) ? dw : total;
    if (dw < total) begin exp_st = 32'h5; tag = "R8 long-table status"; end
    else if (dw == total) begin exp_st = 32'h4; tag = "R6 exact status"; end
    else begin exp_st = 32'h0; tag = "R7 short-table status"; end
    prep(dir, nd, s0, s1);
    dev_start(dw * 4);
    reg_write(OFS(0), dir ? 32'h9 : 32'h1);
    st = 32'h1;
    for (int k = 0; k < 600; k++) begin
      reg_read(OFS(2), st);
      if ((st & 32'h5) != 32'h1) break;
    end
    chk(st == exp_st, tag, st, exp_st);
    chk(irq == exp_st[2], "R11 irq follows INTR", {31'd0, irq}, {31'd0, exp_st[2]});
    repeat (6) @(negedge clk);
    g0 = grants;
    repeat (6) @(negedge clk);
    chk(grants == g0 && !mem_req, "R7 no traffic after end", grants, g0);
    cnt = dir ? dev_idx : rx_n;
    chk(cnt == moved, "R4 words moved", cnt, moved);
    ok = 1'b1;
    if (dir) begin
      for (int j = 0; j < 64; j++) begin
        if (mem[256 + j] != ((j < e0 && j < moved) ? wpat(cur_run, j) : 32'hDEADBEEF)) ok = 1'b0;
        if (mem[320 + j] != ((nd == 2 && j < s1 && e0 + j < moved) ? wpat(cur_run, e0 + j) : 32'hDEADBEEF)) ok = 1'b0;
      end
    end else begin
      for (int g = 0; g < moved && g < 128; g++)
        if (rx[g] != rpat(cur_run, (g < e0) ? 256 + g : 320 + g - e0)) ok = 1'b0;
    end
    chk(ok, "R5 data order across descriptors", {31'd0, ok}, 32'd1);
    if (exp_st == 32'h5) begin
      reg_write(OFS(0), dir ? 32'h8 : 32'h0);
      reg_read(OFS(2), st);
      chk(st == 32'h4, "R8 stop after long table", st, 32'h4);
    end
  endtask

  initial begin
    logic [31:0] v;
    int g0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    reg_read(OFS(0), v); chk(v == 0, "R1 cmd reset", v, 0);
    reg_read(OFS(2), v); chk(v == 0, "R1 status reset", v, 0);
    reg_read(OFS(4), v); chk(v == 0, "R1 pointer reset", v, 0);
    chk(!irq && !mem_req, "R1 irq/mem_req reset", {30'd0, irq, mem_req}, 0);
    // R2 register window
    reg_write(OFS(4), 32'h0000_0107);
    reg_read(OFS(4), v); chk(v == 32'h104, "R2 pointer alignment", v, 32'h104);
    reg_read(OFS(1), v); chk(v == 0, "R2 unused offset", v, 0);
    reg_read(OFS(6), v); chk(v == 0, "R2 unused offset", v, 0);
    reg_write(OFS(0), 32'h8);
    reg_read(OFS(0), v); chk(v == 32'h8, "R2 command readback", v, 32'h8);
    // sweep
    for (int dir = 0; dir < 2; dir++)
      for (int nd = 1; nd <= 2; nd++)
        for (int s0 = 1; s0 <= 4; s0++)
          for (int s1 = 1; s1 <= ((nd == 2) ? 4 : 1); s1++)
            for (int dw = 1; dw <= 8; dw++)
              run_case(dir[0], nd, s0, s1, dw);
    // R3 zero size field means 64 KiB
    run_case(1'b1, 1, 0, 0, 3);
    run_case(1'b0, 1, 0, 0, 5);
    // R9 write-one-to-clear
    run_case(1'b1, 1, 2, 0, 2);
    reg_write(OFS(2), 32'h0);
    reg_read(OFS(2), v); chk(v == 32'h4, "R9 write 0 keeps INTR", v, 32'h4);
    reg_write(OFS(2), 32'h3);
    reg_read(OFS(2), v); chk(v == 32'h4, "R9 bits 0/1 writes ignored", v, 32'h4);
    reg_write(OFS(2), 32'h4);
    reg_read(OFS(2), v); chk(v == 32'h0, "R9 write 1 clears INTR", v, 32'h0);
    chk(!irq, "R11 irq drops with INTR", {31'd0, irq}, 0);
    // R10 stop in the middle
    prep(1'b1, 1, 40, 0);
    stall_en = 1'b1;
    dev_start(160);
    reg_write(OFS(0), 32'h9);
    repeat (10) @(negedge clk);
    reg_write(OFS(0), 32'h8);
    reg_read(OFS(2), v); chk(v == 32'h0, "R10 stop clears ACTIVE", v, 32'h0);
    g0 = grants;
    repeat (20) @(negedge clk);
    chk(grants == g0 && !mem_req, "R10 no requests after stop", grants, g0);
    chk(dev_idx > 0 && dev_idx < 40, "R10 stopped mid transfer", dev_idx, 40);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule